// File: doc/BRIEF.md
# Split Base and Bound Address Translator

This block relocates and limit-checks addresses for a processor that uses segment registers instead of paging. Two independent translation ports run side by side: the fetch port takes the program counter and works through a program segment (base plus bound), and the data port takes load and store effective addresses and works through a separate data segment. Each port adds its segment base to the incoming address to form the physical address. It raises a violation flag when the incoming address is not below the segment bound.

Four registers hold the two segments. A write port updates them, and a read port returns them, but only while the processor runs in supervisor mode. A write tried in user mode changes nothing and raises a one-cycle privilege-violation pulse. In supervisor mode a bypass input passes both addresses through unchanged and with no limit check, so the kernel can reach memory before the segments are set up. After reset every register is zero, so every translated access faults until software programs the segments.

Top module: `split_base_bound_xlate`

## Requirements
- R1: `fetch_phys` equals `fetch_addr + prog_base`, modulo 2^ADDR_W, in the same cycle.
- R2: `data_phys` equals `data_addr + data_base`, modulo 2^ADDR_W, in the same cycle.
- R3: `fetch_fault` is high exactly when `fetch_addr >= prog_bound` as unsigned values, unless bypass is in effect.
- R4: `data_fault` is high exactly when `data_addr >= data_bound` as unsigned values, unless bypass is in effect.
- R5: The two ports work at the same time and independently. The fetch port uses only the program pair and the data port uses only the data pair.
- R6: With `supervisor` high, a write with `cfg_wr_en` high stores `cfg_wdata` into the register picked by `cfg_sel`, and the new value is in use after the next rising clock edge. The `cfg_sel` codes are 0 for program base, 1 for program bound, 2 for data base and 3 for data bound.
- R7: With `supervisor` low, a write leaves all four registers unchanged, and `priv_fault` is high for exactly the one cycle that follows the attempt. In every other case `priv_fault` is low.
- R8: `cfg_rdata` returns the register picked by `cfg_sel` while `supervisor` is high, and returns zero while it is low.
- R9: With both `bypass` and `supervisor` high, each physical address equals its input address and neither fault flag is set. With `supervisor` low, `bypass` has no effect.
- R10: After reset all four registers are zero and `priv_fault` is low, so every translated access faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supervisor | input | 1 | High while the processor is in supervisor mode |
| bypass | input | 1 | Request for untranslated, unchecked access (used only in supervisor mode) |
| fetch_addr | input | ADDR_W | Instruction fetch address from the program counter |
| fetch_phys | output | ADDR_W | Relocated fetch address |
| fetch_fault | output | 1 | Fetch bounds violation |
| data_addr | input | ADDR_W | Load or store effective address |
| data_phys | output | ADDR_W | Relocated data address |
| data_fault | output | 1 | Data bounds violation |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for read and write |
| cfg_wdata | input | ADDR_W | Register write value |
| cfg_rdata | output | ADDR_W | Selected register value (zero in user mode) |
| priv_fault | output | 1 | One-cycle pulse after a user-mode write attempt |

## Verification
On every cycle the assertions check the relation between the address ports, the fault flags and the segment registers. They also check the privilege rules: a user-mode write leaves the registers stable and pulses `priv_fault`, user-mode reads return zero, and bypass only takes effect in supervisor mode. Other behaviour can only be shown by the bench's scenarios. These include the exact boundary at bound minus one versus bound, wrap-around of the sum, and the case where one address faults on the fetch port but not on the data port. They also include the all-fault state right after reset and a readback that proves an ignored write left each register unchanged.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Register select codes; the order is decoded by software.
    typedef enum logic [1:0] {
        SEL_PROG_BASE  = 2'd0,
        SEL_PROG_BOUND = 2'd1,
        SEL_DATA_BASE  = 2'd2,
        SEL_DATA_BOUND = 2'd3
    } seg_sel_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_FETCH = 0;
    localparam int unsigned PORT_DATA = 1;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supervisor,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] prog_base,
    output logic [ADDR_W-1:0] prog_bound,
    output logic [ADDR_W-1:0] data_base,
    output logic [ADDR_W-1:0] data_bound,
    output logic              priv_err
);

    typedef struct packed {
        logic [ADDR_W-1:0] pbase;
        logic [ADDR_W-1:0] pbound;
        logic [ADDR_W-1:0] dbase;
        logic [ADDR_W-1:0] dbound;
        logic              perr;
    } state_t;

    state_t   st_d;
    state_t   st_q;
    seg_sel_e sel_e;

    assign sel_e = seg_sel_e'(sel);

    always_comb begin
        st_d      = st_q;
        st_d.perr = 1'b0;
        if (wr_en) begin
            if (supervisor) begin
                case (sel_e)
                    SEL_PROG_BASE:  st_d.pbase  = wdata;
                    SEL_PROG_BOUND: st_d.pbound = wdata;
                    SEL_DATA_BASE:  st_d.dbase  = wdata;
                    default:        st_d.dbound = wdata;
                endcase
            end else begin
                st_d.perr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Readback is visible only in supervisor mode.
    always_comb begin
        rdata = '0;
        if (supervisor) begin
            case (sel_e)
                SEL_PROG_BASE:  rdata = st_q.pbase;
                SEL_PROG_BOUND: rdata = st_q.pbound;
                SEL_DATA_BASE:  rdata = st_q.dbase;
                default:        rdata = st_q.dbound;
            endcase
        end
    end

    assign prog_base  = st_q.pbase;
    assign prog_bound = st_q.pbound;
    assign data_base  = st_q.dbase;
    assign data_bound = st_q.dbound;
    assign priv_err   = st_q.perr;

endmodule

// File: rtl/seg_port.sv
module seg_port #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              pass_through,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              out_of_range
);

    logic [ADDR_W-1:0] reloc;
    logic              over;

    always_comb begin
        reloc = eff_addr + seg_base;
        over  = (eff_addr >= seg_limit);
        if (pass_through) begin
            phys_addr    = eff_addr;
            out_of_range = 1'b0;
        end else begin
            phys_addr    = reloc;
            out_of_range = over;
        end
    end

endmodule

// File: rtl/split_base_bound_xlate.sv
module split_base_bound_xlate
    import seg_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supervisor,
    input  logic              bypass,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] fetch_phys,
    output logic              fetch_fault,
    input  logic [ADDR_W-1:0] data_addr,
    output logic [ADDR_W-1:0] data_phys,
    output logic              data_fault,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              priv_fault
);

    logic [ADDR_W-1:0] prog_base_w;
    logic [ADDR_W-1:0] prog_bound_w;
    logic [ADDR_W-1:0] data_base_w;
    logic [ADDR_W-1:0] data_bound_w;
    logic              bypass_ok;

    logic [ADDR_W-1:0] port_ea    [NUM_PORTS];
    logic [ADDR_W-1:0] port_base  [NUM_PORTS];
    logic [ADDR_W-1:0] port_limit [NUM_PORTS];
    logic [ADDR_W-1:0] port_phys  [NUM_PORTS];
    logic              port_fault [NUM_PORTS];

    // Bypass is honoured only in supervisor mode.
    assign bypass_ok = bypass & supervisor;

    seg_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .supervisor (supervisor),
        .wr_en      (cfg_wr_en),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .prog_base  (prog_base_w),
        .prog_bound (prog_bound_w),
        .data_base  (data_base_w),
        .data_bound (data_bound_w),
        .priv_err   (priv_fault)
    );

    assign port_ea[PORT_FETCH]    = fetch_addr;
    assign port_base[PORT_FETCH]  = prog_base_w;
    assign port_limit[PORT_FETCH] = prog_bound_w;
    assign port_ea[PORT_DATA]     = data_addr;
    assign port_base[PORT_DATA]   = data_base_w;
    assign port_limit[PORT_DATA]  = data_bound_w;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        seg_port #(.ADDR_W(ADDR_W)) u_port (
            .eff_addr     (port_ea[p]),
            .seg_base     (port_base[p]),
            .seg_limit    (port_limit[p]),
            .pass_through (bypass_ok),
            .phys_addr    (port_phys[p]),
            .out_of_range (port_fault[p])
        );
    end

    assign fetch_phys  = port_phys[PORT_FETCH];
    assign fetch_fault = port_fault[PORT_FETCH];
    assign data_phys   = port_phys[PORT_DATA];
    assign data_fault  = port_fault[PORT_DATA];

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supervisor,
    input logic              bypass,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] fetch_phys,
    input logic              fetch_fault,
    input logic [ADDR_W-1:0] data_addr,
    input logic [ADDR_W-1:0] data_phys,
    input logic              data_fault,
    input logic              cfg_wr_en,
    input logic [1:0]        cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              priv_fault,
    input logic [ADDR_W-1:0] prog_base,
    input logic [ADDR_W-1:0] prog_bound,
    input logic [ADDR_W-1:0] data_base,
    input logic [ADDR_W-1:0] data_bound
);

    logic xlate;
    assign xlate = !(bypass && supervisor);

    assert_fetch_reloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        xlate |-> (fetch_phys - prog_base) == fetch_addr);

    assert_data_reloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xlate |-> (data_phys - data_base) == data_addr);

    assert_fetch_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate && !fetch_fault) |-> fetch_addr < prog_bound);

    assert_data_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate && !data_fault) |-> data_addr < data_bound);

    assert_sup_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && supervisor && cfg_sel == 2'd0) |=> prog_base == $past(cfg_wdata));

    assert_user_write_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !supervisor) |=> ($stable(prog_base) && $stable(prog_bound)
                                        && $stable(data_base) && $stable(data_bound)));

    assert_priv_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !supervisor) |=> priv_fault);

    assert_priv_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && !supervisor) |=> !priv_fault);

    assert_user_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supervisor |-> cfg_rdata == '0);

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && supervisor) |-> (fetch_phys == fetch_addr && data_phys == data_addr
                                    && !fetch_fault && !data_fault));

endmodule

bind split_base_bound_xlate seg_xlate_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supervisor  (supervisor),
    .bypass      (bypass),
    .fetch_addr  (fetch_addr),
    .fetch_phys  (fetch_phys),
    .fetch_fault (fetch_fault),
    .data_addr   (data_addr),
    .data_phys   (data_phys),
    .data_fault  (data_fault),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .priv_fault  (priv_fault),
    .prog_base   (prog_base_w),
    .prog_bound  (prog_bound_w),
    .data_base   (data_base_w),
    .data_bound  (data_bound_w)
);

// File: tb/sim_split_base_bound_xlate.sv
module sim_split_base_bound_xlate;

    localparam int unsigned AW = 32;

    typedef struct packed {
        logic          sup;
        logic          byp;
        logic [AW-1:0] fa;
        logic [AW-1:0] da;
        logic [AW-1:0] exp_fp;
        logic          exp_ff;
        logic [AW-1:0] exp_dp;
        logic          exp_df;
    } vec_t;

    // Segments: prog base 0x1000_0000 bound 0x4000; data base 0x8000_0000 bound 0x1_0000
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h1000_0000, 1'b0, 32'h8000_0000, 1'b0},
        '{1'b0, 1'b0, 32'h0000_3FFF, 32'h0000_FFFF, 32'h1000_3FFF, 1'b0, 32'h8000_FFFF, 1'b0},
        '{1'b0, 1'b0, 32'h0000_4000, 32'h0001_0000, 32'h1000_4000, 1'b1, 32'h8001_0000, 1'b1},
        '{1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_4000, 32'h0FFF_FFFF, 1'b1, 32'h8000_4000, 1'b0},
        '{1'b1, 1'b0, 32'h0000_0100, 32'h0002_0000, 32'h1000_0100, 1'b0, 32'h8002_0000, 1'b1},
        '{1'b1, 1'b1, 32'h0000_5000, 32'h0002_0000, 32'h0000_5000, 1'b0, 32'h0002_0000, 1'b0},
        '{1'b0, 1'b1, 32'h0000_5000, 32'h0000_0020, 32'h1000_5000, 1'b1, 32'h8000_0020, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supervisor = 1'b0;
    logic          bypass = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [AW-1:0] fetch_phys;
    logic          fetch_fault;
    logic [AW-1:0] data_addr = '0;
    logic [AW-1:0] data_phys;
    logic          data_fault;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          priv_fault;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    split_base_bound_xlate #(.ADDR_W(AW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .supervisor  (supervisor),
        .bypass      (bypass),
        .fetch_addr  (fetch_addr),
        .fetch_phys  (fetch_phys),
        .fetch_fault (fetch_fault),
        .data_addr   (data_addr),
        .data_phys   (data_phys),
        .data_fault  (data_fault),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .priv_fault  (priv_fault)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sup, input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        supervisor = sup;
        cfg_wr_en  = 1'b1;
        cfg_sel    = sel;
        cfg_wdata  = val;
        @(negedge clk);
        cfg_wr_en  = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, input logic [AW-1:0] exp, input string req);
        cfg_sel = sel;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        supervisor = 1'b1;
        for (int s = 0; s < 4; s++) read_reg(s[1:0], '0, "R10 reg zero after reset");
        check("R10 priv_fault low", {31'd0, priv_fault}, 32'd0);
        supervisor = 1'b0;
        fetch_addr = '0;
        data_addr  = '0;
        #1;
        check("R10 fetch faults at addr 0", {31'd0, fetch_fault}, 32'd1);
        check("R10 data faults at addr 0", {31'd0, data_fault}, 32'd1);

        // R6: program the segments in supervisor mode
        write_reg(1'b1, 2'd0, 32'h1000_0000);
        write_reg(1'b1, 2'd1, 32'h0000_4000);
        write_reg(1'b1, 2'd2, 32'h8000_0000);
        write_reg(1'b1, 2'd3, 32'h0001_0000);
        read_reg(2'd0, 32'h1000_0000, "R6 prog base");
        read_reg(2'd1, 32'h0000_4000, "R6 prog bound");
        read_reg(2'd2, 32'h8000_0000, "R6 data base");
        read_reg(2'd3, 32'h0001_0000, "R6 data bound");

        // R8: user-mode read returns zero
        supervisor = 1'b0;
        read_reg(2'd0, '0, "R8 user read zero");

        // R1 R2 R3 R4 R5 R9: vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            supervisor = VECS[i].sup;
            bypass     = VECS[i].byp;
            fetch_addr = VECS[i].fa;
            data_addr  = VECS[i].da;
            #1;
            check("R1 R9 fetch_phys", fetch_phys, VECS[i].exp_fp);
            check("R3 R5 R9 fetch_fault", {31'd0, fetch_fault}, {31'd0, VECS[i].exp_ff});
            check("R2 R9 data_phys", data_phys, VECS[i].exp_dp);
            check("R4 R5 R9 data_fault", {31'd0, data_fault}, {31'd0, VECS[i].exp_df});
        end
        bypass = 1'b0;

        // R7: user-mode write ignored, one-cycle pulse
        @(negedge clk);
        supervisor = 1'b0;
        cfg_wr_en  = 1'b1;
        cfg_sel    = 2'd1;
        cfg_wdata  = 32'hDEAD_BEEF;
        @(negedge clk);
        cfg_wr_en  = 1'b0;
        #1;
        check("R7 priv_fault pulse", {31'd0, priv_fault}, 32'd1);
        @(negedge clk);
        #1;
        check("R7 priv_fault single cycle", {31'd0, priv_fault}, 32'd0);
        supervisor = 1'b1;
        read_reg(2'd1, 32'h0000_4000, "R7 prog bound unchanged");
        read_reg(2'd0, 32'h1000_0000, "R7 prog base unchanged");
        supervisor = 1'b0;
        fetch_addr = 32'h0000_3FFF;
        #1;
        check("R7 fetch still in range", {31'd0, fetch_fault}, 32'd0);

        // R6: supervisor write takes effect after the edge
        write_reg(1'b1, 2'd1, 32'h0000_3000);
        supervisor = 1'b0;
        #1;
        check("R6 R3 new bound in use", {31'd0, fetch_fault}, 32'd1);
        check("R6 no priv_fault on sup write", {31'd0, priv_fault}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule